// File: doc/BRIEF.md
# Bucket-Mapping Quasi-Sorter

This block ranks sub-module capacitor voltages without ever comparing two voltages with each other. During a load pass it takes one digitized voltage per accepted sample, in physical order, and quantizes it into one of `M` voltage bins. The sample's arrival index is its position. That position, together with the sub-module's inserted/bypassed flag, is pushed into the FIFO that belongs to the bin. Loading therefore costs one cycle per sub-module, whatever the spread of voltages.

Once all `N` samples are in, a read request sweeps the bins from lowest to highest or from highest to lowest, as the direction input selects. It emits the stored entries as a stream. The result is a list ordered by bin, which is close to sorted. A consumer such as a balancing selector can act on the first entry while the rest is still arriving.

The sample input and the list output are valid/ready streams. Samples are taken only while `in_ready` is high, which covers exactly the load pass. The output honours back-pressure. While `out_valid` is high and `out_ready` is low, the offered entry stays unchanged and nothing is lost. An entry is consumed in a cycle where both are high.

Top module: `bucket_quasi_sorter`

## Requirements
- R1: After reset, `out_valid`, `out_last` and `in_ready` are low, and no list is held.
- R2: A `wr_start` pulse while idle or holding a finished list empties every bin and opens a load pass. During the pass `in_ready` is high, and the k-th accepted sample (counting from 0) gets position k. After N accepted samples `in_ready` drops, and `in_ready` is never high together with `out_valid`.
- R3: The bin of a sample is round-half-up((v − VMIN) / DV), where DV = (VMAX − VMIN) / M. The defaults are VMIN = 1000, VMAX = 1800 and M = 8, so DV = 100, a sample of 1049 lands in bin 0 and a sample of 1050 lands in bin 1.
- R4: Samples below VMIN go to bin 0. A computed bin above M − 1 (for example 1750 or 4000 with the defaults) goes to bin M − 1.
- R5: With `rd_desc` = 0 the list is emitted from bin 0 upward. Within a bin, entries come out in arrival order.
- R6: With `rd_desc` = 1 the list is emitted from bin M − 1 downward. Within a bin, entries still come out in arrival order.
- R7: Each output entry carries the position on `out_pos` and, on `out_ins`, the flag that was presented on `in_ins` with that sample.
- R8: `rd_start` is ignored unless a load pass has completed and its list has not yet been read. This includes a pulse while idle or during a load pass.
- R9: Exactly N entries are emitted per read. `out_last` is high on the N-th entry only, and afterwards `out_valid` stays low.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_pos`, `out_ins` and `out_last` hold their values in the next cycle.
- R11: With `out_ready` held high, the last entry is consumed within N + M cycles after the read starts. Each bin costs at most one cycle without output.
- R12: All N samples may fall into one bin, and the list is then complete, in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_start | input | 1 | Open a new load pass (clears all bins) |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Sample accepted when high with `in_valid` |
| in_volt | input | VW (12) | Digitized capacitor voltage |
| in_ins | input | 1 | Inserted (1) / bypassed (0) flag of the sample |
| rd_start | input | 1 | Request to stream the loaded list |
| rd_desc | input | 1 | Sweep direction: 0 rising, 1 falling |
| out_valid | output | 1 | Entry offered |
| out_ready | input | 1 | Consumer accepts the entry |
| out_pos | output | $clog2(N) (4) | Sub-module position of the entry |
| out_ins | output | 1 | Flag stored with the entry |
| out_last | output | 1 | High on the N-th entry of the list |

## Verification
The hardest situation to reach is a read in which bins that are empty, partly filled and overfull alternate while the consumer stalls. Stalls placed both on an entry and on the cycle where the sweep steps over an empty bin are what expose pointer and hold errors. The stimulus loads a voltage set that hits both sides of the rounding boundaries, both clamp regions and several empty bins. It then reads the set falling with a repeating ready pattern that stalls one cycle in three. A second case piles every sample into a single bin. A third interrupts a finished but unread list with a new load pass, which shows whether stale entries survive the clear.

// File: rtl/bqs_pkg.sv
package bqs_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_WRITE  = 2'd1,
    PH_LOADED = 2'd2,
    PH_READ   = 2'd3
  } phase_e;
endpackage

// File: rtl/bqs_quant.sv
// Voltage-to-bin mapper: multiply by a precomputed reciprocal of the bin
// width, add half an LSB, shift right, then clamp into [0, M-1].
module bqs_quant #(
  parameter int VW   = 12,
  parameter int VMIN = 1000,
  parameter int VMAX = 1800,
  parameter int M    = 8,
  parameter int SH   = 20,
  parameter int AW   = (M > 1) ? $clog2(M) : 1
) (
  input  logic [VW-1:0] volt,
  output logic [AW-1:0] bin
);
  localparam longint SPAN  = longint'(VMAX - VMIN);
  localparam longint RECIP = ((longint'(M) <<< SH) + SPAN / 2) / SPAN;
  localparam longint HALF  = longint'(1) <<< (SH - 1);

  logic [63:0] vx, dx, prod, q;

  always_comb begin
    vx   = 64'(volt);
    dx   = '0;
    prod = '0;
    q    = '0;
    if (vx >= 64'(VMIN)) begin
      dx   = vx - 64'(VMIN);
      prod = dx * 64'(RECIP) + 64'(HALF);
      q    = prod >> SH;
      if (q > 64'(M - 1)) q = 64'(M - 1);
    end
    bin = AW'(q);
  end
endmodule

// File: rtl/bqs_fifo.sv
// One bin: FIFO with synchronous clear, deep enough for every sub-module.
module bqs_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [IW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign do_push = push && (cnt != CW'(DEPTH));
  assign do_pop  = pop && (cnt != '0);
  assign empty   = (cnt == '0);
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == IW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == IW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/bucket_quasi_sorter.sv
module bucket_quasi_sorter #(
  parameter int N    = 16,
  parameter int M    = 8,
  parameter int VW   = 12,
  parameter int VMIN = 1000,
  parameter int VMAX = 1800,
  parameter int SH   = 20
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_start,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [VW-1:0]         in_volt,
  input  logic                  in_ins,
  input  logic                  rd_start,
  input  logic                  rd_desc,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [$clog2(N)-1:0]  out_pos,
  output logic                  out_ins,
  output logic                  out_last
);
  import bqs_pkg::*;

  localparam int PW = $clog2(N);
  localparam int AW = (M > 1) ? $clog2(M) : 1;
  localparam int CW = $clog2(N + 1);
  localparam int EW = PW + 1;

  phase_e        ph;
  logic [CW-1:0] cnt;
  logic [AW-1:0] bptr;
  logic          desc;
  logic [AW-1:0] wbin;
  logic          clr, accept, fire, cur_empty;
  logic [EW-1:0] din, cur_head;
  logic [EW-1:0] heads  [M];
  logic [M-1:0]  empt;
  logic [M-1:0]  push_v, pop_v;

  bqs_quant #(
    .VW(VW), .VMIN(VMIN), .VMAX(VMAX), .M(M), .SH(SH), .AW(AW)
  ) u_quant (
    .volt (in_volt),
    .bin  (wbin)
  );

  assign in_ready  = (ph == PH_WRITE);
  assign accept    = in_valid && in_ready;
  assign clr       = wr_start && (ph == PH_IDLE || ph == PH_LOADED);
  assign din       = {PW'(cnt), in_ins};
  assign cur_empty = empt[bptr];
  assign cur_head  = heads[bptr];
  assign out_valid = (ph == PH_READ) && !cur_empty;
  assign out_pos   = cur_head[EW-1:1];
  assign out_ins   = cur_head[0];
  assign out_last  = out_valid && (cnt == CW'(N - 1));
  assign fire      = out_valid && out_ready;

  for (genvar b = 0; b < M; b++) begin : g_bin
    assign push_v[b] = accept && (wbin == AW'(b));
    assign pop_v[b]  = fire && (bptr == AW'(b));
    bqs_fifo #(.DEPTH(N), .W(EW)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .push  (push_v[b]),
      .din   (din),
      .pop   (pop_v[b]),
      .dout  (heads[b]),
      .empty (empt[b])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph   <= PH_IDLE;
      cnt  <= '0;
      bptr <= '0;
      desc <= 1'b0;
    end else begin
      case (ph)
        PH_IDLE: if (clr) begin
          ph  <= PH_WRITE;
          cnt <= '0;
        end
        PH_WRITE: if (accept) begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(N - 1)) ph <= PH_LOADED;
        end
        PH_LOADED: begin
          if (clr) begin
            ph  <= PH_WRITE;
            cnt <= '0;
          end else if (rd_start) begin
            ph   <= PH_READ;
            cnt  <= '0;
            desc <= rd_desc;
            bptr <= rd_desc ? AW'(M - 1) : '0;
          end
        end
        PH_READ: begin
          if (fire) begin
            cnt <= cnt + 1'b1;
            if (cnt == CW'(N - 1)) ph <= PH_IDLE;
          end else if (cur_empty) begin
            if (desc && bptr != '0)              bptr <= bptr - 1'b1;
            else if (!desc && bptr != AW'(M-1))  bptr <= bptr + 1'b1;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bqs_checker.sv
module bqs_checker #(
  parameter int N  = 16,
  parameter int PW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_start,
  input logic          in_valid,
  input logic          in_ready,
  input logic          rd_start,
  input logic          out_valid,
  input logic          out_ready,
  input logic [PW-1:0] out_pos,
  input logic          out_ins,
  input logic          out_last
);
  localparam int CW = $clog2(N + 1);

  logic          writing, loaded, reading;
  logic [CW-1:0] nin, nout;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      writing <= 1'b0;
      loaded  <= 1'b0;
      reading <= 1'b0;
      nin     <= '0;
      nout    <= '0;
    end else if (wr_start && !writing && !reading) begin
      writing <= 1'b1;
      loaded  <= 1'b0;
      nin     <= '0;
    end else if (writing && in_valid && in_ready) begin
      nin <= nin + 1'b1;
      if (nin == CW'(N - 1)) begin
        writing <= 1'b0;
        loaded  <= 1'b1;
      end
    end else if (loaded && rd_start) begin
      loaded  <= 1'b0;
      reading <= 1'b1;
      nout    <= '0;
    end else if (reading && out_valid && out_ready) begin
      nout <= nout + 1'b1;
      if (out_last) reading <= 1'b0;
    end
  end

  // R2: input side open exactly during a load pass, never with output
  p_ready_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (writing && !out_valid));

  // R8: nothing offered unless a completed list was requested
  p_read_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> reading);

  // R9: last marks the N-th entry
  p_last_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |-> (nout == CW'(N - 1)));

  // R9: no last before the N-th entry
  p_no_early_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && nout != CW'(N - 1)) |-> !out_last);

  // R10: stalled entry is held
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pos) &&
                                   $stable(out_ins) && $stable(out_last)));
endmodule

bind bucket_quasi_sorter bqs_checker #(.N(N), .PW($clog2(N))) u_chk (.*);

// File: tb/sim_bucket_quasi_sorter.sv
`timescale 1ns/1ps
module sim_bucket_quasi_sorter;
  localparam int N = 16, M = 8, VW = 12, VMIN = 1000, VMAX = 1800;
  localparam int PW = $clog2(N);
  localparam int DV = (VMAX - VMIN) / M;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_start = 0, in_valid = 0, in_ins = 0, rd_start = 0, rd_desc = 0;
  logic out_ready = 1;
  logic [VW-1:0] in_volt = '0;
  logic in_ready, out_valid, out_ins, out_last;
  logic [PW-1:0] out_pos;

  always #2 clk = ~clk;

  bucket_quasi_sorter #(.N(N), .M(M), .VW(VW), .VMIN(VMIN), .VMAX(VMAX)) u0 (
    .clk, .rst_n, .wr_start, .in_valid, .in_ready, .in_volt, .in_ins,
    .rd_start, .rd_desc, .out_valid, .out_ready, .out_pos, .out_ins, .out_last);

  int checks = 0, errors = 0;
  int exp_q[$];
  int vv [N];
  bit ii [N];
  bit busy = 0, done = 0, bp_mode = 0, finished = 0;
  int rdcyc = 0, tick = 0;
  string cur_req = "R5";
  bit stall_prev = 0;
  int stall_pos = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int bin_of(int v);
    int b;
    if (v < VMIN) return 0;
    b = (v - VMIN + DV / 2) / DV;
    if (b > M - 1) b = M - 1;
    return b;
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (busy) rdcyc++;
    if (stall_prev) begin
      chk(out_valid && (int'(out_pos) == stall_pos), "R10", int'(out_pos), stall_pos);
    end
    stall_prev = out_valid && !out_ready;
    stall_pos  = int'(out_pos);
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk(0, "R9", int'(out_pos), -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        chk(int'({out_pos, out_ins}) == e, cur_req, int'({out_pos, out_ins}), e);
        chk(out_last == (exp_q.size() == 0), "R9", int'(out_last), int'(exp_q.size() == 0));
      end
      if (out_last) begin
        busy = 0;
        done = 1;
      end
    end
  end

  // ready pattern driver
  always @(posedge clk) begin
    tick++;
    #1 out_ready = bp_mode ? (tick % 3 != 0) : 1'b1;
  end

  task automatic open_load();
    wr_start = 1;
    @(posedge clk); #1;
    wr_start = 0;
  endtask

  task automatic feed(bit rd_mid);
    for (int p = 0; p < N; p++) begin
      chk(in_ready, "R2", int'(in_ready), 1);
      in_valid = 1; in_volt = VW'(vv[p]); in_ins = ii[p];
      rd_start = rd_mid && (p == N / 2);
      @(posedge clk); #1;
      in_valid = 0; rd_start = 0;
      if (p % 2 == 1) begin @(posedge clk); #1; end
    end
    chk(!in_ready, "R2", int'(in_ready), 0);
  endtask

  task automatic read_list(bit d, string req);
    exp_q.delete();
    for (int k = 0; k < M; k++) begin
      int b;
      b = d ? (M - 1 - k) : k;
      for (int p = 0; p < N; p++)
        if (bin_of(vv[p]) == b) exp_q.push_back(p * 2 + int'(ii[p]));
    end
    cur_req = req;
    rd_desc = d; rd_start = 1; done = 0; rdcyc = 0; busy = 1;
    @(posedge clk); #1;
    rd_start = 0;
    while (!done) begin @(posedge clk); #1; end
    chk(exp_q.size() == 0, "R9", exp_q.size(), 0);
    @(negedge clk);
    chk(!out_valid, "R9", int'(out_valid), 0);
    @(posedge clk); #1;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(!out_valid, "R1", int'(out_valid), 0);
    chk(!in_ready, "R1", int'(in_ready), 0);
    chk(!out_last, "R1", int'(out_last), 0);

    // R8: read in idle is ignored
    @(posedge clk); #1 rd_start = 1;
    @(posedge clk); #1 rd_start = 0;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      chk(!out_valid, "R8", int'(out_valid), 0);
    end

    // Pattern A: boundaries, clamps (R3, R4), rising read (R5, R7, R11)
    vv = '{500, 1049, 1050, 1200, 1749, 1750, 4000, 1000,
           1340, 1460, 1550, 1101, 1800, 1300, 1649, 1420};
    for (int p = 0; p < N; p++) ii[p] = p[0] ^ p[2];
    chk(bin_of(1049) == 0 && bin_of(1050) == 1, "R3", bin_of(1050), 1);
    chk(bin_of(4000) == M - 1 && bin_of(500) == 0, "R4", bin_of(4000), M - 1);
    @(posedge clk); #1;
    open_load();
    feed(0);
    read_list(0, "R5");
    chk(rdcyc <= N + M, "R11", rdcyc, N + M);

    // falling read of the same set with back-pressure (R6, R10)
    open_load();
    feed(0);
    bp_mode = 1;
    read_list(1, "R6");
    bp_mode = 0;

    // R12: everything in one bin
    for (int p = 0; p < N; p++) begin vv[p] = 1400 + (p % 3); ii[p] = p[1]; end
    open_load();
    feed(0);
    read_list(0, "R12");

    // R8 mid-load read ignored; R2 clear on reload of an unread list
    for (int p = 0; p < N; p++) begin vv[p] = 1800 - p * 37; ii[p] = 1'b1; end
    open_load();
    feed(1);
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      chk(!out_valid, "R8", int'(out_valid), 0);
    end
    @(posedge clk); #1;
    for (int p = 0; p < N; p++) begin vv[p] = 1100 + p * 45; ii[p] = p[0]; end
    open_load();
    feed(0);
    bp_mode = 1;
    read_list(1, "R2");
    bp_mode = 0;

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule